// File: doc/BRIEF.md
# Buffered Auto-Transfer Serial Master

This block is a synchronous serial master that works through a small on-chip byte buffer without help from a processor. Software fills the buffer, sets a last address and a clock divisor, and writes a start command. The engine then walks a pointer upward from address 0. For each byte it shifts the stored value out most-significant bit first and shifts a byte in at the same time. The received byte replaces the sent byte at the same buffer address.

In single-pass mode the walk stops after the byte at the last address, and a one-cycle done pulse marks the end. In repeat mode the pointer wraps back to 0 after the last address. The walk continues until repeat is cleared, which lets the current pass finish, or a stop command is written, which ends the walk after the current byte. The serial clock idles high. Data changes on its falling edge and the far end samples on its rising edge. The host's buffer port is fenced off while a transfer runs.

Top module: `bxm_master`

## Requirements
- R1: After reset the divisor select reads 3, the last address reads 0, busy and done are low, and sclk and mosi are high. Whenever busy is low, sclk is high.
- R2: Divisor select values 0, 1, 2 and 3 give serial clock periods of 6, 8, 16 and 32 base cycles. Each low phase lasts exactly half the period.
- R3: Configuration select 0 holds the divisor in bits [1:0]. Select 1 holds the last address in bits [4:0], and bits [7:5] always read 0. Select 2 is control: bit 0 is repeat (it reads back), a 1 in bit 1 starts a transfer, and a 1 in bit 2 stops one.
- R4: Writes to the divisor or the last address are ignored while busy is high.
- R5: The bytes at addresses 0 through the last address are sent in ascending order, MSB first. Each bit is driven at a falling sclk edge and is stable at the following rising edge.
- R6: The byte sampled from miso on the rising edges replaces the byte at the address just sent. Addresses above the last address are left untouched.
- R7: Busy rises the cycle after a start command. In single-pass mode busy stays high for (last+1)·8·ratio cycles and then falls, and done pulses for exactly one cycle as busy falls.
- R8: In repeat mode the pointer wraps to address 0 after the last address. Clearing repeat ends the transfer after the next byte at the last address.
- R9: A stop command while busy ends the transfer after the byte in progress.
- R10: While busy is high, host buffer writes are dropped and host buffer reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select (0 divisor, 1 last address, 2 control) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read-back of the selected configuration register |
| buf_we | input | 1 | Host buffer write strobe |
| buf_addr | input | 5 | Host buffer address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Host buffer read data (0 while busy) |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume that reset is held for at least one clock. They also assume that a start command is issued only while busy is low, since a start written while busy is high is simply ignored. The bench writes a start only after busy has fallen and it has waited a few idle cycles. It ties miso to the inverse of mosi, so each byte written back is the complement of the byte sent. The bench places its writes during a transfer well inside a byte period, so that which byte a stop or a repeat-clear takes effect on is never in doubt.

// File: rtl/bxm_pkg.sv
package bxm_pkg;

    typedef enum logic [1:0] {
        CFG_DIV = 2'd0,
        CFG_END = 2'd1,
        CFG_CTL = 2'd2
    } cfg_sel_e;

    // half of the serial clock period, in base cycles
    function automatic logic [4:0] div_half(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd3;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/bxm_clkgen.sv
module bxm_clkgen
    import bxm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] div_sel,
    output logic       tick
);
    logic [4:0] cnt_q;
    logic [4:0] half_m1;

    assign half_m1 = div_half(div_sel) - 5'd1;
    assign tick    = run && (cnt_q == half_m1);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q == half_m1)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 5'd1;
    end
endmodule

// File: rtl/bxm_shifter.sv
module bxm_shifter #(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          tick,
    input  logic          miso,
    output logic          sclk,
    output logic          tx_bit,
    output logic [DW-1:0] rx_byte,
    output logic          byte_end
);
    logic [DW-1:0] sh_q;
    logic [BW-1:0] bc_q;

    assign tx_bit   = sh_q[DW-1];
    assign byte_end = tick && sclk && (bc_q == BW'(DW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            bc_q    <= '0;
            rx_byte <= '0;
            sclk    <= 1'b1;
        end else if (load) begin
            sh_q <= load_data;
            bc_q <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            if (!sclk) begin
                sclk    <= 1'b1;
                rx_byte <= {rx_byte[DW-2:0], miso};
            end else if (bc_q != BW'(DW - 1)) begin
                sh_q <= {sh_q[DW-2:0], 1'b0};
                bc_q <= bc_q + BW'(1);
                sclk <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bxm_buffer.sv
module bxm_buffer #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra_host,
    output logic [DW-1:0] rd_host,
    input  logic [AW-1:0] ra_eng,
    output logic [DW-1:0] rd_eng
);
    logic [DW-1:0] mem [DEPTH];

    assign rd_host = mem[ra_host];
    assign rd_eng  = mem[ra_eng];

    always_ff @(posedge clk) begin
        if (we)
            mem[wa] <= wd;
    end
endmodule

// File: rtl/bxm_master.sv
module bxm_master
    import bxm_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic          buf_we,
    input  logic [AW-1:0] buf_addr,
    input  logic [DW-1:0] buf_wdata,
    output logic [DW-1:0] buf_rdata,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          busy,
    output logic          done
);
    logic [1:0]    div_q;
    logic [AW-1:0] last_q, ptr_q, nxt_ptr, eng_ra;
    logic          rpt_q, stop_q, busy_q, done_q;
    logic          div_wr, end_wr, ctl_wr, start_cmd;
    logic          tick, byte_end, tx_bit, at_last, go_on, load;
    logic [DW-1:0] rx_byte, eng_rd, host_rd, load_data;
    logic          mem_we;
    logic [AW-1:0] mem_wa;
    logic [DW-1:0] mem_wd;

    assign div_wr    = cfg_we && (cfg_sel == CFG_DIV);
    assign end_wr    = cfg_we && (cfg_sel == CFG_END);
    assign ctl_wr    = cfg_we && (cfg_sel == CFG_CTL);
    assign start_cmd = ctl_wr && cfg_wdata[1] && !busy_q;

    assign at_last   = (ptr_q == last_q);
    assign nxt_ptr   = at_last ? '0 : ptr_q + AW'(1);
    assign go_on     = byte_end && !stop_q && !(at_last && !rpt_q);
    assign load      = start_cmd || go_on;
    assign eng_ra    = start_cmd ? '0 : nxt_ptr;
    // a one-entry repeat walk resends the byte it has just received
    assign load_data = (!start_cmd && nxt_ptr == ptr_q) ? rx_byte : eng_rd;

    assign mem_we = byte_end || (buf_we && !busy_q);
    assign mem_wa = byte_end ? ptr_q   : buf_addr;
    assign mem_wd = byte_end ? rx_byte : buf_wdata;

    bxm_clkgen u_clk (
        .clk(clk), .rst(rst), .run(busy_q), .div_sel(div_q), .tick(tick)
    );

    bxm_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst(rst), .load(load), .load_data(load_data),
        .tick(tick), .miso(miso), .sclk(sclk), .tx_bit(tx_bit),
        .rx_byte(rx_byte), .byte_end(byte_end)
    );

    bxm_buffer #(.DEPTH(DEPTH), .DW(DW)) u_buf (
        .clk(clk), .we(mem_we), .wa(mem_wa), .wd(mem_wd),
        .ra_host(buf_addr), .rd_host(host_rd),
        .ra_eng(eng_ra), .rd_eng(eng_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= 2'd3;
            last_q <= '0;
            rpt_q  <= 1'b0;
            stop_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            ptr_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (div_wr && !busy_q)
                div_q <= cfg_wdata[1:0];
            if (end_wr && !busy_q)
                last_q <= cfg_wdata[AW-1:0];
            if (ctl_wr) begin
                rpt_q <= cfg_wdata[0];
                if (cfg_wdata[2] && busy_q)
                    stop_q <= 1'b1;
            end
            if (start_cmd) begin
                busy_q <= 1'b1;
                ptr_q  <= '0;
                stop_q <= 1'b0;
            end else if (byte_end) begin
                if (go_on) begin
                    ptr_q <= nxt_ptr;
                end else begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    stop_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        case (cfg_sel)
            CFG_DIV: cfg_rdata = {6'b0, div_q};
            CFG_END: cfg_rdata = 8'(last_q);
            CFG_CTL: cfg_rdata = {7'b0, rpt_q};
            default: cfg_rdata = 8'h00;
        endcase
    end

    assign buf_rdata = busy_q ? '0 : host_rd;
    assign mosi      = busy_q ? tx_bit : 1'b1;
    assign busy      = busy_q;
    assign done      = done_q;
endmodule

// File: rtl/bxm_master_chk.sv
module bxm_master_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [1:0]    cfg_sel,
    input logic [7:0]    cfg_wdata,
    input logic          busy,
    input logic          done,
    input logic          sclk,
    input logic          mosi,
    input logic [1:0]    div_q,
    input logic [AW-1:0] last_q
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk && mosi));

    p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(div_q) && $stable(last_q)));

    p_bit_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && sclk && $past(sclk) && $past(busy)) |-> $stable(mosi));

    p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd2 && cfg_wdata[1] && !busy) |=> busy);

    p_done_at_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy ##1 !done));
endmodule

bind bxm_master bxm_master_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .done(done), .sclk(sclk),
    .mosi(mosi), .div_q(div_q), .last_q(last_q)
);

// File: tb/bxm_master_test.sv
module bxm_master_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       buf_we = 1'b0;
    logic [4:0] buf_addr = 5'd0;
    logic [7:0] buf_wdata = 8'h00;
    logic [7:0] buf_rdata;
    logic       sclk, mosi, miso, busy, done;

    int checks = 0;
    int errors = 0;
    logic [7:0] orig [32];
    logic [7:0] expb [64];

    // monitor state (written only by the monitor)
    int busy_cnt = 0, done_cnt = 0, low_run = 0, low_err = 0, bit_idx = 0;
    logic prev_sclk = 1'b1;
    logic bitlog [4096];
    int cur_half = 16;

    always #5 clk = ~clk;
    assign miso = ~mosi;

    bxm_master uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy), .done(done)
    );

    always @(negedge clk) begin
        if (busy === 1'b1) busy_cnt++;
        if (done === 1'b1) done_cnt++;
        if (sclk === 1'b0) low_run++;
        if (sclk === 1'b1 && prev_sclk === 1'b0) begin
            bitlog[bit_idx % 4096] = mosi;
            bit_idx++;
            if (low_run != cur_half) low_err++;
        end
        if (sclk === 1'b1) low_run = 0;
        prev_sclk = sclk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic buf_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = a; buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 32; i++) begin
            orig[i] = 8'((i * 29 + seed * 13) ^ 8'h5A);
            buf_write(5'(i), orig[i]);
        end
    endtask

    task automatic wait_idle();
        while (busy === 1'b1) @(negedge clk);
        repeat (4) @(negedge clk);
        #1;
    endtask

    // compare nbytes of logged bits starting at base against expb
    task automatic check_stream(input int base, input int nbytes, input string req);
        int bad = 0;
        for (int k = 0; k < nbytes; k++)
            for (int j = 0; j < 8; j++)
                if (bitlog[(base + k * 8 + j) % 4096] !== expb[k][7 - j]) bad++;
        check(bad == 0 && bit_idx - base == nbytes * 8, req, bit_idx - base, nbytes * 8);
    endtask

    // buffer must hold ~orig for i < ninv, orig elsewhere
    task automatic check_buf(input int ninv, input string req);
        int bad = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            buf_addr = 5'(i);
            #1;
            if (buf_rdata !== ((i < ninv) ? ~orig[i] : orig[i])) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic run_single(input int d, input int e);
        int b0, d0, l0, x0, n;
        n = (d == 0) ? 6 : (d == 1) ? 8 : (d == 2) ? 16 : 32;
        cur_half = n / 2;
        cfg_write(2'd0, 8'(d));
        cfg_write(2'd1, 8'(e));
        fill(d * 4 + e);
        @(negedge clk); #1;
        b0 = busy_cnt; d0 = done_cnt; l0 = low_err; x0 = bit_idx;
        for (int k = 0; k <= e; k++) expb[k] = orig[k];
        cfg_write(2'd2, 8'h02);
        wait_idle();
        check(busy_cnt - b0 == (e + 1) * 8 * n, "R7 busy length", busy_cnt - b0, (e + 1) * 8 * n);
        check(done_cnt - d0 == 1, "R7 done pulse count", done_cnt - d0, 1);
        check(low_err == l0, "R2 sclk low phase", low_err - l0, 0);
        check_stream(x0, e + 1, "R5 mosi byte stream");
        check_buf(e + 1, "R6 buffer write-back");
        check(sclk === 1'b1 && mosi === 1'b1, "R1 idle lines", int'(sclk), 1);
    endtask

    initial begin
        logic [7:0] rv;
        int b0, x0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;

        // R1 reset state
        check(busy === 1'b0 && done === 1'b0, "R1 busy/done low", int'(busy), 0);
        check(sclk === 1'b1 && mosi === 1'b1, "R1 sclk/mosi high", int'(sclk), 1);
        cfg_read(2'd0, rv);
        check(rv == 8'd3, "R1 divisor reset", rv, 3);
        cfg_read(2'd1, rv);
        check(rv == 8'd0, "R1 last address reset", rv, 0);

        // R3 register fields
        cfg_write(2'd1, 8'hFF);
        cfg_read(2'd1, rv);
        check(rv == 8'h1F, "R3 last address upper bits", rv, 8'h1F);
        cfg_write(2'd0, 8'hFE);
        cfg_read(2'd0, rv);
        check(rv == 8'h02, "R3 divisor field", rv, 2);
        cfg_write(2'd2, 8'h01);
        cfg_read(2'd2, rv);
        check(rv == 8'h01, "R3 repeat bit", rv, 1);
        cfg_write(2'd2, 8'h00);
        check(busy === 1'b0, "R3 control write without start", int'(busy), 0);

        // R2/R5/R6/R7 sweep over all ratios and several last addresses
        for (int d = 0; d < 4; d++) begin
            run_single(d, 0);
            run_single(d, 5);
            run_single(d, 31);
        end

        // R4/R10 writes during a transfer
        cfg_write(2'd0, 8'd1);
        cfg_write(2'd1, 8'd3);
        fill(77);
        cur_half = 4;
        @(negedge clk); #1;
        b0 = busy_cnt;
        cfg_write(2'd2, 8'h02);
        repeat (30) @(negedge clk);
        cfg_write(2'd0, 8'd0);
        cfg_write(2'd1, 8'd9);
        buf_write(5'd20, 8'hEE);
        @(negedge clk);
        buf_addr = 5'd20;
        #1 check(buf_rdata === 8'h00, "R10 read while busy", buf_rdata, 0);
        wait_idle();
        check(busy_cnt - b0 == 4 * 64, "R4 busy length unchanged", busy_cnt - b0, 256);
        cfg_read(2'd0, rv);
        check(rv == 8'd1, "R4 divisor kept", rv, 1);
        cfg_read(2'd1, rv);
        check(rv == 8'd3, "R4 last address kept", rv, 3);
        check_buf(4, "R10 buffer write dropped");

        // R8 repeat: wrap, then clear repeat during the second pass
        cfg_write(2'd0, 8'd0);
        cfg_write(2'd1, 8'd2);
        fill(91);
        cur_half = 3;
        for (int k = 0; k < 3; k++) begin
            expb[k] = orig[k];
            expb[k + 3] = ~orig[k];
        end
        @(negedge clk); #1;
        b0 = busy_cnt; x0 = bit_idx;
        cfg_write(2'd2, 8'h03);
        repeat (200) @(negedge clk);
        check(busy === 1'b1, "R8 still busy after wrap", int'(busy), 1);
        cfg_write(2'd2, 8'h00);
        wait_idle();
        check(busy_cnt - b0 == 6 * 48, "R8 repeat length", busy_cnt - b0, 288);
        check_stream(x0, 6, "R8 wrapped stream");
        check_buf(0, "R8 double inversion");

        // R9 stop during the third byte
        cfg_write(2'd1, 8'd31);
        fill(5);
        for (int k = 0; k < 3; k++) expb[k] = orig[k];
        @(negedge clk); #1;
        b0 = busy_cnt; x0 = bit_idx;
        cfg_write(2'd2, 8'h02);
        repeat (110) @(negedge clk);
        cfg_write(2'd2, 8'h04);
        wait_idle();
        check(busy_cnt - b0 == 3 * 48, "R9 stop length", busy_cnt - b0, 144);
        check_stream(x0, 3, "R9 stream before stop");
        check_buf(3, "R9 buffer after stop");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule